// File: doc/BRIEF.md
# Event Timer Global Block

This block is the shared front end of a multi-channel event timer. It keeps the free-running main up-counter and three global registers: a read-only capability word, a two-bit configuration register and an interrupt status register. It also decodes a 1 KiB window of 32-bit registers. The counter advances by one on each cycle where `tick_en` is high, but only while the global enable is set. Clearing the enable freezes the count, and setting it again resumes from the held value.

Offsets from 0x100 to 0x3ff belong to the timer channels. The block splits each such offset into a channel index and a register offset inside a 32-byte slot. It forwards the access to the channel side in the same cycle, and returns the channel's read data on the following clock. Channel internals and interrupt routing are not part of this block. The channels report events through `evt_in`, and software clears those status bits by writing ones.

Top module: `evt_timer_global`

## Requirements
- R1: After reset, the counter, the configuration bits, the status bits, the write-error flag and `rd_data` are all zero.
- R2: A read at 0x000 returns the capability word. Bits 31:16 hold the vendor code, bit 15 marks legacy routing, bit 13 is 0 (32-bit counter), bits 12:8 hold NUM_TIMERS-1 and bits 7:0 hold the revision, which gives 0x80868201 by default. A read at 0x004 returns the tick period in femtoseconds. Writes to either offset change nothing.
- R3: At 0x010, bit 0 is the global enable (`glb_en`) and bit 1 is legacy routing (`legacy_en`). Only these two bits can be written, and all other bits read 0.
- R4: While enabled, the counter increments by one on each cycle with `tick_en` high and holds on other cycles. While disabled it holds its value, and it continues from that value once re-enabled.
- R5: A write at 0x0f0 replaces counter bits 31:0, and a write at 0x0f4 replaces the bits above 31. Reads of 0x0f0 return bits 31:0 and reads of 0x0f4 return 0. A carry from bit 31 reaches the upper bits.
- R6: A counter write made while enabled is still applied, and it also sets `cnt_wr_err`. That flag stays set until reset.
- R7: Status bit i (offset 0x020, bit i) is set by a pulse on `evt_in[i]`. Writing a 1 to bit i at 0x020 clears it, and an event in the same cycle wins over the clear.
- R8: For offsets 0x100 to 0x3ff, `ch_idx` is (offset-0x100)/32 and `ch_reg` is offset mod 32. `ch_req` is high in the cycle of the access, and a read returns `ch_rdata` on `rd_data` one clock later.
- R9: If the channel index is NUM_TIMERS or larger, `ch_req` stays low and reads return 0.
- R10: Any offset below 0x100 that is not listed above, including 0x008, 0x014 and 0x024, reads 0 and ignores writes.
- R11: `rd_data` is updated only by reads and keeps its value on idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick qualifier |
| evt_in | input | NUM_TIMERS | Per-channel event pulses into the status register |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one clock after a read |
| ch_req | output | 1 | Access forwarded to an existing channel |
| ch_write | output | 1 | Direction of the forwarded access |
| ch_idx | output | 5 | Channel index of the forwarded access |
| ch_reg | output | 5 | Byte offset inside the channel slot |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | 32 | Read data from the selected channel |
| glb_en | output | 1 | Global enable |
| legacy_en | output | 1 | Legacy routing select |
| cnt_val | output | CNT_W | Main counter value |
| irq_status | output | NUM_TIMERS | Interrupt status bits |
| cnt_wr_err | output | 1 | Sticky flag: counter written while enabled |

## Verification
The bench builds the block with three channels, a 64-bit counter and a 10 ns tick period. With three channels, most of the 24 slots in the channel window are beyond the last channel, so the out-of-range path can be exercised at both ends of the window. The 64-bit counter makes the carry from bit 31 into the upper word visible on `cnt_val`, even though the upper word always reads as zero. A behavioural model tracks every register and is compared with the outputs on each clock. This covers fixed sequences and a stretch of random ticks, events and reads.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int SLOT_W = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_PERIOD,
    SEL_CFG,
    SEL_STAT,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CHAN
  } reg_sel_e;

  // word indices (byte offset >> 2) of the global registers
  localparam logic [5:0] W_CAP    = 6'h00;
  localparam logic [5:0] W_PERIOD = 6'h01;
  localparam logic [5:0] W_CFG    = 6'h04;
  localparam logic [5:0] W_STAT   = 6'h08;
  localparam logic [5:0] W_CNT_LO = 6'h3C;
  localparam logic [5:0] W_CNT_HI = 6'h3D;

  // capability word: vendor | legacy-capable | rsvd | size(0=32b) | timers-1 | revision
  function automatic logic [31:0] cap_word(input logic [15:0] vendor,
                                           input logic        leg_cap,
                                           input int          num_timers,
                                           input logic [7:0]  rev);
    logic [4:0] last;
    last = 5'(num_timers - 1);
    return {vendor, leg_cap, 1'b0, 1'b0, last, rev};
  endfunction

  // channel slot number for an offset inside 0x100..0x3ff
  function automatic logic [SLOT_W-1:0] slot_of(input logic [9:0] addr);
    return addr[9:5] - 5'd8;
  endfunction

  // next status bits: W1C clear first, new events win
  function automatic logic [31:0] status_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic [9:0]        addr,
  output reg_sel_e          sel,
  output logic [SLOT_W-1:0] slot,
  output logic [4:0]        slot_off,
  output logic              slot_ok
);

  always_comb begin
    sel = SEL_NONE;
    if (addr[9:8] != 2'b00) begin
      sel = SEL_CHAN;
    end else begin
      case (addr[7:2])
        W_CAP:    sel = SEL_CAP;
        W_PERIOD: sel = SEL_PERIOD;
        W_CFG:    sel = SEL_CFG;
        W_STAT:   sel = SEL_STAT;
        W_CNT_LO: sel = SEL_CNT_LO;
        W_CNT_HI: sel = SEL_CNT_HI;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  assign slot     = slot_of(addr);
  assign slot_off = addr[4:0];
  assign slot_ok  = (sel == SEL_CHAN) && (int'(slot) < NUM_TIMERS);

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lo_repl;
  logic [CNT_W-1:0] hi_repl;
  logic [CNT_W-1:0] cnt_d;

  generate
    if (CNT_W > 32) begin : g_wide
      assign lo_repl = {cnt_q[CNT_W-1:32], wdata};
      assign hi_repl = {wdata[CNT_W-33:0], cnt_q[31:0]};
    end else begin : g_narrow
      assign lo_repl = wdata[CNT_W-1:0];
      assign hi_repl = cnt_q;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)            cnt_d = lo_repl;
    else if (wr_hi)       cnt_d = hi_repl;
    else if (run && tick) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);

  logic [31:0] cur_w, clr_w, evt_w, nxt_w;

  assign cur_w = 32'(status);
  assign clr_w = clr_wr ? 32'(clr_mask) : 32'd0;
  assign evt_w = 32'(evt);
  assign nxt_w = evt_timer_pkg::status_next(cur_w, clr_w, evt_w);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= nxt_w[i];
      end
    end
  endgenerate

endmodule

// File: rtl/evt_timer_global.sv
module evt_timer_global
  import evt_timer_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          CNT_W      = 64,
  parameter logic [31:0] PERIOD_FS  = 32'd10_000_000,
  parameter logic [15:0] VENDOR     = 16'h8086,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic        LEGACY_CAP = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic [NUM_TIMERS-1:0] evt_in,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [9:0]            req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rd_data,
  output logic                  ch_req,
  output logic                  ch_write,
  output logic [SLOT_W-1:0]     ch_idx,
  output logic [4:0]            ch_reg,
  output logic [31:0]           ch_wdata,
  input  logic [31:0]           ch_rdata,
  output logic                  glb_en,
  output logic                  legacy_en,
  output logic [CNT_W-1:0]      cnt_val,
  output logic [NUM_TIMERS-1:0] irq_status,
  output logic                  cnt_wr_err
);

  localparam logic [31:0] CAP_LO = cap_word(VENDOR, LEGACY_CAP, NUM_TIMERS, REVISION);

  reg_sel_e          sel;
  logic [SLOT_W-1:0] slot;
  logic [4:0]        slot_off;
  logic              slot_ok;

  // named access events, used by the checker
  logic acc_rd, acc_wr;
  logic wr_cfg, wr_stat, wr_cnt_lo, wr_cnt_hi, wr_cnt_any;
  logic [31:0] rd_mux;

  evt_addr_decode #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr     (req_addr),
    .sel      (sel),
    .slot     (slot),
    .slot_off (slot_off),
    .slot_ok  (slot_ok)
  );

  assign acc_rd     = req_valid && !req_write;
  assign acc_wr     = req_valid &&  req_write;
  assign wr_cfg     = acc_wr && (sel == SEL_CFG);
  assign wr_stat    = acc_wr && (sel == SEL_STAT);
  assign wr_cnt_lo  = acc_wr && (sel == SEL_CNT_LO);
  assign wr_cnt_hi  = acc_wr && (sel == SEL_CNT_HI);
  assign wr_cnt_any = wr_cnt_lo || wr_cnt_hi;

  // general configuration: two writable bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en    <= 1'b0;
      legacy_en <= 1'b0;
    end else if (wr_cfg) begin
      glb_en    <= req_wdata[0];
      legacy_en <= req_wdata[1];
    end
  end

  // sticky: counter written while running
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_wr_err <= 1'b0;
    else if (wr_cnt_any && glb_en) cnt_wr_err <= 1'b1;
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (glb_en),
    .tick  (tick_en),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (req_wdata),
    .cnt   (cnt_val)
  );

  evt_status_reg #(.N(NUM_TIMERS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_in),
    .clr_wr   (wr_stat),
    .clr_mask (req_wdata[NUM_TIMERS-1:0]),
    .status   (irq_status)
  );

  // channel forwarding
  assign ch_req   = req_valid && slot_ok;
  assign ch_write = req_write;
  assign ch_idx   = slot;
  assign ch_reg   = slot_off;
  assign ch_wdata = req_wdata;

  always_comb begin
    case (sel)
      SEL_CAP:    rd_mux = CAP_LO;
      SEL_PERIOD: rd_mux = PERIOD_FS;
      SEL_CFG:    rd_mux = {30'd0, legacy_en, glb_en};
      SEL_STAT:   rd_mux = 32'(irq_status);
      SEL_CNT_LO: rd_mux = cnt_val[31:0];
      SEL_CNT_HI: rd_mux = 32'd0;
      SEL_CHAN:   rd_mux = slot_ok ? ch_rdata : 32'd0;
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= 32'd0;
    else if (acc_rd) rd_data <= rd_mux;
  end

endmodule

// File: rtl/evt_timer_global_chk.sv
module evt_timer_global_chk #(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_en,
  input logic [NUM_TIMERS-1:0] evt_in,
  input logic                  glb_en,
  input logic [CNT_W-1:0]      cnt_val,
  input logic [NUM_TIMERS-1:0] irq_status,
  input logic                  cnt_wr_err,
  input logic                  wr_cnt_any,
  input logic                  ch_req,
  input logic [4:0]            ch_idx,
  input logic                  acc_rd,
  input logic [31:0]           rd_data
);

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_cnt_any) |=> $stable(cnt_val));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick_en && !wr_cnt_any) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && wr_cnt_any) |=> cnt_wr_err);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_err |=> cnt_wr_err);

  a_r7_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((irq_status & $past(evt_in)) == $past(evt_in)));

  a_r9_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req |-> (int'(ch_idx) < NUM_TIMERS));

  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rd_data));

endmodule

bind evt_timer_global evt_timer_global_chk #(
  .NUM_TIMERS(NUM_TIMERS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .evt_in     (evt_in),
  .glb_en     (glb_en),
  .cnt_val    (cnt_val),
  .irq_status (irq_status),
  .cnt_wr_err (cnt_wr_err),
  .wr_cnt_any (wr_cnt_any),
  .ch_req     (ch_req),
  .ch_idx     (ch_idx),
  .acc_rd     (acc_rd),
  .rd_data    (rd_data)
);

// File: tb/sim_evt_timer_global.sv
`timescale 1ns/1ps
module sim_evt_timer_global;

  localparam int          NT     = 3;
  localparam int          CW     = 64;
  localparam logic [31:0] PER_FS = 32'd10_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic [NT-1:0] evt_in = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [9:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic          ch_req, ch_write;
  logic [4:0]    ch_idx, ch_reg;
  logic [31:0]   ch_wdata, ch_rdata;
  logic          glb_en, legacy_en, cnt_wr_err;
  logic [CW-1:0] cnt_val;
  logic [NT-1:0] irq_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [63:0]   m_cnt = '0;
  logic          m_en = 1'b0, m_leg = 1'b0, m_err = 1'b0;
  logic [NT-1:0] m_st = '0;
  logic [31:0]   m_rd = '0;

  always #5 clk = ~clk;

  // channel side stub: data encodes the slot and register it was asked for
  assign ch_rdata = {16'hC0DE, 3'b000, ch_idx, 3'b000, ch_reg};

  evt_timer_global #(.NUM_TIMERS(NT), .CNT_W(CW), .PERIOD_FS(PER_FS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data),
    .ch_req(ch_req), .ch_write(ch_write), .ch_idx(ch_idx), .ch_reg(ch_reg),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .glb_en(glb_en), .legacy_en(legacy_en), .cnt_val(cnt_val),
    .irq_status(irq_status), .cnt_wr_err(cnt_wr_err)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(int a);
    if (a >= 256) begin
      int s;
      int r;
      s = (a - 256) / 32;
      r = a % 32;
      if (s < NT) return {16'hC0DE, 3'b000, 5'(s), 3'b000, 5'(r)};
      return 32'd0;
    end
    case (a)
      0:       return 32'h8086_8201;
      4:       return PER_FS;
      16:      return {30'd0, m_leg, m_en};
      32:      return 32'(m_st);
      240:     return m_cnt[31:0];
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp_state(string tag);
    chk(tag, "cnt_val", cnt_val, m_cnt);
    chk(tag, "glb_en", 64'(glb_en), 64'(m_en));
    chk(tag, "legacy_en", 64'(legacy_en), 64'(m_leg));
    chk(tag, "irq_status", 64'(irq_status), 64'(m_st));
    chk(tag, "cnt_wr_err", 64'(cnt_wr_err), 64'(m_err));
    chk(tag, "rd_data", 64'(rd_data), 64'(m_rd));
  endtask

  // one clock: drive at negedge, check forwarding, model the edge, compare
  task automatic step(string tag, bit v, bit w, int a, logic [31:0] d,
                      bit tk, logic [NT-1:0] ev);
    bit exp_req;
    req_valid = v; req_write = w; req_addr = 10'(a); req_wdata = d;
    tick_en = tk; evt_in = ev;
    #1;
    exp_req = v && (a >= 256) && (((a - 256) / 32) < NT);
    chk(tag, "ch_req", 64'(ch_req), 64'(exp_req));
    if (exp_req) begin
      chk(tag, "ch_idx", 64'(ch_idx), 64'((a - 256) / 32));
      chk(tag, "ch_reg", 64'(ch_reg), 64'(a % 32));
      chk(tag, "ch_write", 64'(ch_write), 64'(w));
      if (w) chk(tag, "ch_wdata", 64'(ch_wdata), 64'(d));
    end
    @(posedge clk);
    begin
      bit en0;
      en0 = m_en;
      if (v && !w) m_rd = ref_read(a);
      if (v && w && a == 240) begin
        m_cnt[31:0] = d; m_err = m_err | en0;
      end else if (v && w && a == 244) begin
        m_cnt[63:32] = d; m_err = m_err | en0;
      end else if (en0 && tk) begin
        m_cnt = m_cnt + 64'd1;
      end
      if (v && w && a == 16) begin
        m_en = d[0]; m_leg = d[1];
      end
      m_st = (m_st & ~((v && w && a == 32) ? d[NT-1:0] : '0)) | ev;
    end
    @(negedge clk);
    cmp_state(tag);
  endtask

  task automatic idle(string tag, int n, bit tk);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, tk, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cmp_state("R1");
    idle("R1", 2, 1);

    // R2: capability and period, writes ignored
    step("R2", 1, 0, 0, 0, 0, '0);
    chk("R2", "cap", 64'(rd_data), 64'h8086_8201);
    step("R2", 1, 0, 4, 0, 0, '0);
    step("R2", 1, 1, 0, 32'hFFFF_FFFF, 0, '0);
    step("R2", 1, 1, 4, 32'h1234_5678, 0, '0);
    step("R2", 1, 0, 0, 0, 0, '0);
    step("R2", 1, 0, 4, 0, 0, '0);
    chk("R2", "period", 64'(rd_data), 64'(PER_FS));

    // R3: only two config bits
    step("R3", 1, 1, 16, 32'hFFFF_FFFE, 1, '0);
    step("R3", 1, 0, 16, 0, 1, '0);
    chk("R3", "cfg", 64'(rd_data), 64'h2);
    step("R3", 1, 1, 16, 32'hFFFF_FFFF, 1, '0);
    step("R3", 1, 0, 16, 0, 1, '0);
    chk("R3", "cfg", 64'(rd_data), 64'h3);

    // R4: counting, freezing, resuming
    for (int i = 0; i < 10; i++) step("R4", 0, 0, 0, 0, (i % 3) != 0, '0);
    step("R4", 1, 1, 16, 32'h0, 1, '0);
    idle("R4", 6, 1);
    step("R4", 1, 0, 240, 0, 1, '0);
    step("R4", 1, 1, 16, 32'h1, 0, '0);
    idle("R4", 5, 1);
    step("R4", 1, 0, 240, 0, 1, '0);

    // R5: counter writes while disabled, carry into upper bits
    step("R5", 1, 1, 16, 32'h0, 0, '0);
    step("R5", 1, 1, 240, 32'hFFFF_FFFE, 1, '0);
    step("R5", 1, 1, 244, 32'h0000_0012, 1, '0);
    step("R5", 1, 0, 244, 0, 1, '0);
    chk("R5", "hi read", 64'(rd_data), 64'h0);
    step("R5", 1, 0, 240, 0, 1, '0);
    chk("R5", "lo read", 64'(rd_data), 64'hFFFF_FFFE);
    step("R5", 1, 1, 16, 32'h1, 0, '0);
    idle("R5", 3, 1);
    chk("R5", "carry", cnt_val, 64'h0000_0013_0000_0001);

    // R6: write while running is applied and flagged
    chk("R6", "err before", 64'(cnt_wr_err), 64'h0);
    step("R6", 1, 1, 240, 32'h0000_0100, 1, '0);
    chk("R6", "err", 64'(cnt_wr_err), 64'h1);
    step("R6", 1, 1, 16, 32'h0, 0, '0);
    idle("R6", 4, 1);

    // R7: status set, W1C, event beats clear
    step("R7", 0, 0, 0, 0, 0, 3'b101);
    step("R7", 1, 0, 32, 0, 0, '0);
    chk("R7", "status read", 64'(rd_data), 64'h5);
    step("R7", 1, 1, 32, 32'h1, 0, '0);
    chk("R7", "w1c", 64'(irq_status), 64'h4);
    step("R7", 1, 1, 32, 32'h6, 0, 3'b010);
    chk("R7", "set wins", 64'(irq_status), 64'h2);

    // R8: channel forwarding
    step("R8", 1, 0, 32'h100, 0, 0, '0);
    step("R8", 1, 0, 32'h128, 0, 0, '0);
    step("R8", 1, 0, 32'h15C, 0, 0, '0);
    chk("R8", "slot2", 64'(rd_data), 64'hC0DE_021C);
    step("R8", 1, 1, 32'h140, 32'hA5A5_0001, 0, '0);
    // R11: read data held
    idle("R11", 3, 0);
    chk("R11", "hold", 64'(rd_data), 64'hC0DE_021C);

    // R9: slots past the last channel
    step("R9", 1, 0, 32'h160, 0, 0, '0);
    chk("R9", "slot3", 64'(rd_data), 64'h0);
    step("R9", 1, 1, 32'h3FC, 32'hFFFF_FFFF, 0, '0);
    step("R9", 1, 0, 32'h3FC, 0, 0, '0);

    // R10: unmapped offsets
    step("R10", 1, 1, 16, 32'h1, 0, '0);
    step("R10", 1, 1, 20, 32'hFFFF_FFFF, 0, '0);
    step("R10", 1, 1, 8, 32'hFFFF_FFFF, 0, '0);
    step("R10", 1, 1, 36, 32'hFFFF_FFFF, 0, '0);
    step("R10", 1, 0, 20, 0, 0, '0);
    chk("R10", "0x014", 64'(rd_data), 64'h0);
    step("R10", 1, 0, 36, 0, 0, '0);
    step("R10", 1, 0, 8, 0, 0, '0);
    step("R10", 1, 0, 16, 0, 0, '0);
    chk("R10", "cfg kept", 64'(rd_data), 64'h1);

    // random ticks, events and reads (R4 R7 R8)
    for (int i = 0; i < 300; i++) begin
      int k;
      k = int'($urandom_range(0, 7));
      case (k)
        0:       step("R4", 1, 0, 240, 0, $urandom_range(0, 1) == 1, '0);
        1:       step("R7", 1, 0, 32, 0, 1, NT'($urandom_range(0, 7)));
        2:       step("R7", 1, 1, 32, $urandom, 1, NT'($urandom_range(0, 7)));
        3:       step("R8", 1, 0, 256 + 4 * int'($urandom_range(0, 191)), 0, 1, '0);
        4:       step("R4", 1, 1, 16, {31'd0, 1'($urandom_range(0, 1))}, 1, '0);
        default: step("R4", 0, 0, 0, 0, $urandom_range(0, 1) == 1, '0);
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule